// File: doc/BRIEF.md
# PHY Management Interface Master

This block drives the two-wire PHY management bus (MDC clock, bidirectional MDIO data) from a pair of software-visible registers: a 16-bit data register and a command register. To write a PHY register, software first loads the value into the data register. It then issues a command word that holds the go bit, the operation, a clock-range select and the two 5-bit addresses. To read, software issues the command alone. Software then polls the go bit, which reads back as busy while the frame is on the wire. When the bit drops, a read result is in the low 16 bits of the data register.

Command register layout (register select 1):

| Bits | Field |
|------|-------|
| 0 | go on write, busy on read |
| 1 | op: 1 read, 0 write |
| 4:2 | range: the MDC half-period is 2^range clock cycles |
| 12:8 | PHY register number |
| 20:16 | PHY address |

All other bits read back as 0. The data register is at register select 0 and uses bits 15:0.

A single state machine sequences the frame. Its states are IDLE, PREAMBLE, HEADER, TURN and DATA:
- IDLE to PREAMBLE on an accepted go command.
- PREAMBLE to HEADER after the MDC falling edge that ends bit 31.
- HEADER to TURN after bit 45.
- TURN to DATA after bit 47.
- DATA to IDLE after bit 63.

Each bit ends on an MDC falling edge, and the master changes MDIO only on those edges.

Top module: `mdio_master`

## Requirements
- R1: After reset the busy bit, the data register and the command fields read 0, MDC is low and MDIO is not driven (mdio_oe = 0).
- R2: A command write with bit 0 set while idle starts a frame of exactly 64 MDC rising edges. Bit 0 reads 1 until the last MDC falling edge and 0 afterwards.
- R3: A write frame (bit 1 = 0) is driven throughout and carries, MSB first: 32 ones, 01, 01, the PHY address, the register number, 10, then the data register value.
- R4: A read frame (bit 1 = 1) drives 32 ones, 01, 10, the PHY address and the register number (46 bits). MDIO is then released (mdio_oe = 0) for the 2 turnaround bits and the 16 data bits.
- R5: In a read, mdio_i is sampled at each of the last 16 MDC rising edges, first bit as bit 15. The result is in data register bits 15:0 (bits 31:16 read 0) once busy has cleared.
- R6: The MDC half-period is 2^range clock cycles, so busy stays set for exactly 128·2^range clock cycles.
- R7: MDC is low whenever no transaction is in progress.
- R8: A command write while busy is ignored. The stored fields and the frame on the wire are unchanged, and no second frame follows.
- R9: While driven during a frame, MDIO changes only together with an MDC falling edge.
- R10: A command write with bit 0 clear stores the fields but starts nothing. Busy stays 0 and MDC stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the data register, 1 selects the command register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach from the ports is a second command that lands in the middle of a frame. It has to arrive while the first frame's fields are still being shifted out, and its effect can only be seen in what follows. The bench issues that command while it is polling busy, 20 cycles into a slow frame. It then reads the command register back during the same frame. After completion it compares the whole captured 64-bit frame, and it watches that no further MDC edges appear. A behavioural PHY in the bench records MDIO and the enable at every MDC rise. The same PHY model returns chosen read data, so that the bit order of both directions is checked at the pins.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

    localparam int PREAMBLE_LEN = 32;
    localparam int START_LEN    = 2;
    localparam int OPCODE_LEN   = 2;
    localparam int TURN_LEN     = 2;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int RANGE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RANGE_W-1:0] range_sel,
    output logic               mdc,
    output logic               rise,
    output logic               fall
);
    localparam int CNT_W = 1 << RANGE_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             hit;

    assign limit = (CNT_W'(1) << range_sel) - CNT_W'(1);
    assign hit   = en && (cnt == limit);
    assign rise  = hit && !mdc;
    assign fall  = hit && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (hit) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mdio_serdes.sv
module mdio_serdes #(
    parameter int FRAME_BITS = 64,
    parameter int DATA_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_frame,
    input  logic                  shift,
    input  logic                  capture,
    input  logic                  sin,
    output logic                  sout,
    output logic [DATA_W-1:0]     rdata
);
    logic [FRAME_BITS-1:0] out_sr;

    assign sout = out_sr[FRAME_BITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sr <= '0;
            rdata  <= '0;
        end else begin
            if (load) begin
                out_sr <= load_frame;
            end else if (shift) begin
                out_sr <= {out_sr[FRAME_BITS-2:0], 1'b1};
            end
            if (load) begin
                rdata <= '0;
            end else if (capture) begin
                rdata <= {rdata[DATA_W-2:0], sin};
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 5,
    parameter int RANGE_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_pkg::*;

    localparam int HDR_BITS   = PREAMBLE_LEN + START_LEN + OPCODE_LEN + 2 * ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + TURN_LEN + DATA_W;
    localparam int BC_W       = $clog2(FRAME_BITS);
    localparam int PRE_LAST   = PREAMBLE_LEN - 1;
    localparam int HDR_LAST   = HDR_BITS - 1;
    localparam int TURN_LAST  = HDR_BITS + TURN_LEN - 1;
    localparam int DATA_LAST  = FRAME_BITS - 1;
    localparam int OP_BIT     = 1;
    localparam int RANGE_LSB  = 2;
    localparam int REG_LSB    = 8;
    localparam int PHY_LSB    = 16;

    mdio_state_e state, nxt;
    logic [BC_W-1:0]    bitcnt;
    logic [ADDR_W-1:0]  phy_q, reg_q;
    logic [RANGE_W-1:0] range_q;
    logic               rd_q;
    logic [DATA_W-1:0]  data_q;
    logic [FRAME_BITS-1:0] frame;
    logic [DATA_W-1:0]  shift_in;
    logic               busy, accept, cmd_wr, done;
    logic               mdc_rise, mdc_fall, clk_en, capture, sout;
    logic [31:0]        cmd_rb;
    logic               unused_wbits;

    assign unused_wbits = ^reg_wdata;
    assign cmd_wr = reg_we && reg_sel && (state == ST_IDLE);
    assign accept = cmd_wr && reg_wdata[0];
    assign done   = mdc_fall && (state == ST_DATA) && (bitcnt == BC_W'(DATA_LAST));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                bitcnt <= '0;
            end else if (mdc_fall) begin
                bitcnt <= bitcnt + BC_W'(1);
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (accept) nxt = ST_PREAMBLE;
            ST_PREAMBLE: if (mdc_fall && bitcnt == BC_W'(PRE_LAST))  nxt = ST_HEADER;
            ST_HEADER:   if (mdc_fall && bitcnt == BC_W'(HDR_LAST))  nxt = ST_TURN;
            ST_TURN:     if (mdc_fall && bitcnt == BC_W'(TURN_LAST)) nxt = ST_DATA;
            ST_DATA:     if (done) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        busy    = (state != ST_IDLE);
        clk_en  = busy;
        mdio_oe = busy && !(rd_q && (state == ST_TURN || state == ST_DATA));
        capture = mdc_rise && rd_q && (state == ST_DATA);
        mdio_o  = sout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_q   <= '0;
            reg_q   <= '0;
            range_q <= '0;
            rd_q    <= 1'b0;
        end else if (cmd_wr) begin
            phy_q   <= reg_wdata[PHY_LSB +: ADDR_W];
            reg_q   <= reg_wdata[REG_LSB +: ADDR_W];
            range_q <= reg_wdata[RANGE_LSB +: RANGE_W];
            rd_q    <= reg_wdata[OP_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (done && rd_q) begin
            data_q <= shift_in;
        end else if (reg_we && !reg_sel) begin
            data_q <= reg_wdata[DATA_W-1:0];
        end
    end

    always_comb begin
        if (reg_wdata[OP_BIT]) begin
            frame = {{PREAMBLE_LEN{1'b1}}, 2'b01, 2'b10,
                     reg_wdata[PHY_LSB +: ADDR_W], reg_wdata[REG_LSB +: ADDR_W],
                     2'b11, {DATA_W{1'b1}}};
        end else begin
            frame = {{PREAMBLE_LEN{1'b1}}, 2'b01, 2'b01,
                     reg_wdata[PHY_LSB +: ADDR_W], reg_wdata[REG_LSB +: ADDR_W],
                     2'b10, data_q};
        end
    end

    always_comb begin
        cmd_rb = '0;
        cmd_rb[0] = busy;
        cmd_rb[OP_BIT] = rd_q;
        cmd_rb[RANGE_LSB +: RANGE_W] = range_q;
        cmd_rb[REG_LSB +: ADDR_W] = reg_q;
        cmd_rb[PHY_LSB +: ADDR_W] = phy_q;
    end

    assign reg_rdata = reg_sel ? cmd_rb : {{(32 - DATA_W){1'b0}}, data_q};

    mdio_clkgen #(.RANGE_W(RANGE_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .range_sel (range_q),
        .mdc       (mdc),
        .rise      (mdc_rise),
        .fall      (mdc_fall)
    );

    mdio_serdes #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W)) u_serdes (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_frame (frame),
        .shift      (mdc_fall),
        .capture    (capture),
        .sin        (mdio_i),
        .sout       (sout),
        .rdata      (shift_in)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int FW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mdc,
    input logic          mdio_o,
    input logic          mdio_oe,
    input logic          reg_we,
    input logic          reg_sel,
    input logic          go_bit,
    input logic [FW-1:0] fields
);
    // R7
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R2
    start_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && reg_sel && go_bit));

    // R8
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fields));

    // R9
    mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && mdio_oe && $past(mdio_oe) && !$fell(mdc)) |-> $stable(mdio_o));

    // R7
    end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !mdc);
endmodule

bind mdio_master mdio_master_chk #(.FW(2 * ADDR_W + RANGE_W + 1)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .reg_we  (reg_we),
    .reg_sel (reg_sel),
    .go_bit  (reg_wdata[0]),
    .fields  ({phy_q, reg_q, range_q, rd_q})
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit timeout = 0;

    // behavioural PHY state
    int          rise_total = 0;
    int          base = 0;
    int          mon_idx;
    int          mon_pos;
    logic        mdc_prev = 1'b0;
    logic [15:0] phy_val = '0;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;

    // {rd, range[2:0], phy[4:0], reg[4:0], value[15:0]}
    localparam logic [29:0] VEC [6] = '{
        {1'b0, 3'd0, 5'd1,  5'd0,  16'hA5C3},
        {1'b1, 3'd0, 5'd31, 5'd31, 16'h1234},
        {1'b0, 3'd1, 5'd10, 5'd21, 16'hFFFF},
        {1'b1, 3'd2, 5'd0,  5'd2,  16'h8001},
        {1'b0, 3'd3, 5'd21, 5'd10, 16'h0000},
        {1'b1, 3'd1, 5'd5,  5'd17, 16'h7FFE}
    };

    always #2.5 clk = ~clk;

    mdio_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            mon_idx = rise_total - base;
            if (mon_idx >= 0 && mon_idx < 64) begin
                cap_o[6'(63 - mon_idx)]  = mdio_o;
                cap_oe[6'(63 - mon_idx)] = mdio_oe;
            end
            rise_total = rise_total + 1;
        end
        mdc_prev = mdc;
        mon_pos = rise_total - base;
        mdio_i = (mon_pos >= 48 && mon_pos < 64) ? phy_val[4'(63 - mon_pos)] : 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 1'b1;
    endtask

    function automatic logic [31:0] cmd_word(input logic rd, input logic [2:0] rng,
                                             input logic [4:0] phy, input logic [4:0] ra, input logic go);
        return {11'b0, phy, 3'b0, ra, 3'b0, rng, rd, go};
    endfunction

    task automatic run_txn(input logic rd, input logic [2:0] rng, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] val, input bit intrude);
        int cycles;
        logic [63:0] exp_f, mask;
        if (!rd) reg_write(1'b0, {16'h0, val});
        phy_val = val;
        base = rise_total;
        reg_write(1'b1, cmd_word(rd, rng, phy, ra, 1'b1));
        cycles = 0;
        while (reg_rdata[0] && !timeout) begin
            if (intrude && cycles == 20) begin
                reg_we = 1'b1;
                reg_wdata = cmd_word(1'b1, 3'd0, 5'd9, 5'd1, 1'b1);
            end else begin
                reg_we = 1'b0;
            end
            if (intrude && cycles == 30)
                check(reg_rdata[20:16] == phy && reg_rdata[1] == rd, "R8 fields during busy",
                      {59'b0, reg_rdata[20:16]}, {59'b0, phy});
            cycles++;
            @(negedge clk);
        end
        reg_we = 1'b0;
        check(cycles == (128 << rng), "R6 busy length", 64'(cycles), 64'(128 << rng));
        check(rise_total - base == 64, "R2 rising edges per frame", 64'(rise_total - base), 64'd64);
        exp_f = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, val};
        mask  = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        check((cap_o & mask) == (exp_f & mask), rd ? "R4 read header" : "R3 write frame",
              cap_o & mask, exp_f & mask);
        check(cap_oe == mask, rd ? "R4 release" : "R3 driven", cap_oe, mask);
        check(mdc == 1'b0, "R7 mdc low at end", {63'b0, mdc}, 64'd0);
        if (rd) begin
            reg_sel = 1'b0;
            #0.1;
            check(reg_rdata == {16'h0, val}, "R5 read data", {32'b0, reg_rdata}, {48'b0, val});
            reg_sel = 1'b1;
        end
        if (intrude) begin
            repeat (40) @(negedge clk);
            check(rise_total - base == 64 && !reg_rdata[0], "R8 no second frame",
                  64'(rise_total - base), 64'd64);
        end
    endtask

    task automatic run_all();
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_sel = 1'b1; #0.1;
        check(reg_rdata == 32'h0, "R1 command after reset", {32'b0, reg_rdata}, 64'd0);
        reg_sel = 1'b0; #0.1;
        check(reg_rdata == 32'h0, "R1 data after reset", {32'b0, reg_rdata}, 64'd0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins after reset", {62'b0, mdc, mdio_oe}, 64'd0);
        reg_sel = 1'b1;

        for (int i = 0; i < 6; i++) begin
            run_txn(VEC[i][29], VEC[i][28:26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0], 1'b0);
            if (timeout) return;
        end

        // R10 command without go
        r0 = rise_total;
        reg_write(1'b1, cmd_word(1'b1, 3'd0, 5'd7, 5'd6, 1'b0));
        repeat (40) begin
            @(negedge clk);
            if (mdc) r0 = -1000;
        end
        check(reg_rdata[0] == 1'b0 && rise_total == r0, "R10 no start without go",
              {63'b0, reg_rdata[0]}, 64'd0);
        check(reg_rdata[20:16] == 5'd7 && reg_rdata[12:8] == 5'd6, "R10 fields stored",
              {32'b0, reg_rdata}, 64'h0007_0602);

        // R8 command during busy
        run_txn(1'b0, 3'd1, 5'd3, 5'd4, 16'h5A5A, 1'b1);
        if (timeout) return;
        // R6 slowest divider with a read
        run_txn(1'b1, 3'd7, 5'd2, 5'd3, 16'hC0DE, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timeout = 1;
            end
        join_any
        if (timeout) begin
            errors++;
            $display("FAIL watchdog: actual expired expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule